// File: doc/BRIEF.md
# Reset Cause Status and Soft Reset Control Register

This block holds one 32-bit register that tells software why the system last came out of reset, and lets software ask for a new reset. A soft reset request comes in two kinds. A soft power-on request makes the next system reset count as a fresh power-on. A soft externally-initiated request resets the system without that effect. Two hardware inputs report reset-button events, one for each kind.

The register sits at the upper word of an 8-byte slot. The lower word always reads zero and ignores writes. Status bits are cleared by writing a one to them. Request bits can only be set by software and are cleared only by a system reset that treats itself as a power-on. When software writes a request bit, the block raises a one-cycle request pulse for the system reset sequencer. A qualifier output says whether the request is the power-on kind.

A power-up reset (`rst_ni`) clears the register and arms power-on detection. The first system reset (`sys_rst_i`) after power-up, or after a soft power-on request, loads the register with only the power-on flag set. Every later system reset leaves the register unchanged.

Top module: `reset_cause_reg`

## Requirements
- R1: After power-up reset (`rst_ni` low) the register reads 0x00000000 and no request is raised.
- R2: The first system reset after power-up loads the register with 0x80000000 (power-on flag, bit 31, alone).
- R3: A system reset that is not the first one after power-up or re-arm leaves the register unchanged.
- R4: Writing a one to bit 31 (power-on), bit 28 (button power-on) or bit 27 (button external) clears that bit. Writing a zero to any of these bits leaves it unchanged.
- R5: Writing a one to bit 30 (soft power-on) or bit 29 (soft external) sets that bit. Writing a zero to these bits never clears them.
- R6: Bits 26 to 0 always read zero, and write data in those positions has no effect.
- R7: The register is selected only when `addr_i[2]` is 1. With `addr_i[2]` at 0, reads return zero and writes change nothing and raise no request.
- R8: A write with bit 30 set raises `rst_req_o` together with `rst_req_por_o` in the following cycle. It also re-arms power-on detection, so the next system reset loads 0x80000000.
- R9: A write with bit 29 set and bit 30 clear raises `rst_req_o` with `rst_req_por_o` low in the following cycle. Power-on detection stays disarmed.
- R10: A one-cycle pulse on `btn_por_i` sets bit 28, and a pulse on `btn_xir_i` sets bit 27. If a button event and a write-one-to-clear of the same bit fall in the same cycle, the bit ends up set.
- R11: `rst_req_o` is high for exactly one cycle per requesting write. A write with neither bit 30 nor bit 29 set raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-up reset, active low |
| sys_rst_i | input | 1 | Synchronous system reset event, active high |
| btn_por_i | input | 1 | Button power-on reset event pulse |
| btn_xir_i | input | 1 | Button externally-initiated reset event pulse |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 3 | Byte address within the slot; bit 2 selects the register word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the addressed word |
| rst_req_o | output | 1 | One-cycle system reset request |
| rst_req_por_o | output | 1 | The request being raised is the power-on kind |

## Verification
The assertions assume that `sys_rst_i`, the button inputs and the write port are all synchronous to `clk_i`. They also assume these inputs are quiet while `rst_ni` is low. The one-cycle request property additionally assumes that software never issues two requesting writes in consecutive cycles. The stimulus changes every input only at falling edges and holds them idle during the power-up reset. It always separates requesting writes with at least one idle cycle, which is also when the request pulse and its qualifier are observed.

// File: rtl/reset_cause_reg.sv
module reset_cause_reg #(
  parameter int          DW            = 32,
  parameter int          AW            = 3,
  parameter int          SEL_BIT       = 2,
  parameter int          PWR_BIT       = 31,
  parameter int          SPOR_BIT      = 30,
  parameter int          SXIR_BIT      = 29,
  parameter int          BPOR_BIT      = 28,
  parameter int          BXIR_BIT      = 27,
  parameter logic [31:0] KEEP_MASK     = 32'hF800_0000,
  parameter logic [31:0] W1C_MASK      = 32'h9800_0000,
  parameter logic [31:0] SET_MASK      = 32'h6000_0000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sys_rst_i,
  input  logic          btn_por_i,
  input  logic          btn_xir_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rst_req_o,
  output logic          rst_req_por_o
);

  localparam logic [DW-1:0] KEEP   = KEEP_MASK[DW-1:0];
  localparam logic [DW-1:0] W1C    = W1C_MASK[DW-1:0];
  localparam logic [DW-1:0] SETM   = SET_MASK[DW-1:0];
  localparam logic [DW-1:0] PWR_ON = DW'(1) << PWR_BIT;

  logic [DW-1:0] stat_q;
  logic          arm_q;
  logic          req_q;
  logic          kind_q;

  wire           hit    = wr_en_i && addr_i[SEL_BIT];
  wire [DW-1:0]  wd     = wdata_i & KEEP;
  wire [DW-1:0]  evt    = (DW'(btn_por_i) << BPOR_BIT) | (DW'(btn_xir_i) << BXIR_BIT);
  wire           w_spor = hit && wd[SPOR_BIT];
  wire           w_sxir = hit && wd[SXIR_BIT];
  wire [DW-1:0]  wr_nxt = hit ? ((stat_q & ~(wd & W1C)) | (wd & SETM)) : stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      arm_q  <= 1'b1;
      req_q  <= 1'b0;
      kind_q <= 1'b0;
    end else if (sys_rst_i) begin
      if (arm_q) stat_q <= PWR_ON;
      arm_q  <= 1'b0;
      req_q  <= 1'b0;
      kind_q <= 1'b0;
    end else begin
      stat_q <= (wr_nxt | evt) & KEEP;
      if (w_spor) arm_q <= 1'b1;
      req_q  <= w_spor || w_sxir;
      kind_q <= w_spor;
    end
  end

  assign rdata_o       = addr_i[SEL_BIT] ? stat_q : '0;
  assign rst_req_o     = req_q;
  assign rst_req_por_o = kind_q;

endmodule

// File: rtl/reset_cause_reg_chk.sv
module reset_cause_reg_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sys_rst_i,
  input logic        wr_en_i,
  input logic [2:0]  addr_i,
  input logic [31:0] wdata_i,
  input logic [31:0] rdata_o,
  input logic        rst_req_o,
  input logic        rst_req_por_o,
  input logic [31:0] stat_q,
  input logic        arm_q
);

  wire wr_req = wr_en_i && addr_i[2] && (wdata_i[30] || wdata_i[29]) && !sys_rst_i;

  a_r2_first_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_i && arm_q) |=> (stat_q == 32'h8000_0000));

  a_r3_later_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_i && !arm_q) |=> $stable(stat_q));

  a_r4_w1c_pwr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i[2] && wdata_i[31] && !sys_rst_i) |=> !stat_q[31]);

  a_r6_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[26:0] == 27'd0);

  a_r7_lower_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_i[2] |-> (rdata_o == 32'd0));

  a_r8_por_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i[2] && wdata_i[30] && !sys_rst_i) |=> (rst_req_o && rst_req_por_o && arm_q));

  a_r9_xir_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i[2] && wdata_i[29] && !wdata_i[30] && !sys_rst_i) |=> (rst_req_o && !rst_req_por_o));

  a_r11_req_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> $past(wr_req));

  a_r11_req_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_req_o && !wr_req) |=> !rst_req_o);

endmodule

bind reset_cause_reg reset_cause_reg_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sys_rst_i     (sys_rst_i),
  .wr_en_i       (wr_en_i),
  .addr_i        (addr_i),
  .wdata_i       (wdata_i),
  .rdata_o       (rdata_o),
  .rst_req_o     (rst_req_o),
  .rst_req_por_o (rst_req_por_o),
  .stat_q        (stat_q),
  .arm_q         (arm_q)
);

// File: tb/tb_reset_cause_reg.sv
module tb_reset_cause_reg;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sys_rst = 1'b0;
  logic        bpor = 1'b0;
  logic        bxir = 1'b0;
  logic        wr = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic        req;
  logic        req_por;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] rd;
    logic        rq;
    logic        kd;
    string       tag;
  } exp_t;

  exp_t q[$];

  always #10 clk = ~clk;

  reset_cause_reg dut (
    .clk_i(clk), .rst_ni(rst_n), .sys_rst_i(sys_rst),
    .btn_por_i(bpor), .btn_xir_i(bxir),
    .wr_en_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .rst_req_o(req), .rst_req_por_o(req_por)
  );

  task automatic step(input logic w, input logic [2:0] a, input logic [31:0] d,
                      input logic sr, input logic bp, input logic bx);
    @(negedge clk);
    wr = w; addr = a; wdata = d; sys_rst = sr; bpor = bp; bxir = bx;
  endtask

  task automatic chk(input logic [2:0] a, input logic [31:0] rd, input logic rq,
                     input logic kd, input string tag);
    exp_t e;
    @(negedge clk);
    wr = 1'b0; addr = a; wdata = '0; sys_rst = 1'b0; bpor = 1'b0; bxir = 1'b0;
    e.rd = rd; e.rq = rq; e.kd = kd; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (rdata !== e.rd || req !== e.rq || req_por !== e.kd) begin
          errors++;
          $display("FAIL %s: rdata=%h req=%b por=%b, expected rdata=%h req=%b por=%b",
                   e.tag, rdata, req, req_por, e.rd, e.rq, e.kd);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk(3'd4, 32'h0000_0000, 0, 0, "R1 upper after power-up");
    chk(3'd0, 32'h0000_0000, 0, 0, "R1 lower after power-up");
    step(0, 3'd4, 0, 1, 0, 0);
    chk(3'd4, 32'h8000_0000, 0, 0, "R2 first system reset");
    step(0, 3'd4, 0, 1, 0, 0);
    chk(3'd4, 32'h8000_0000, 0, 0, "R3 second system reset");
    step(1, 3'd4, 32'h8000_0000, 0, 0, 0);
    chk(3'd4, 32'h0000_0000, 0, 0, "R4 clear bit 31");
    step(0, 3'd4, 0, 0, 1, 0);
    chk(3'd4, 32'h1000_0000, 0, 0, "R10 button power-on");
    step(0, 3'd4, 0, 0, 0, 1);
    chk(3'd4, 32'h1800_0000, 0, 0, "R10 button external");
    step(1, 3'd4, 32'h0800_0000, 0, 0, 0);
    chk(3'd4, 32'h1000_0000, 0, 0, "R4 clear bit 27 only");
    step(1, 3'd4, 32'h07FF_FFFF, 0, 0, 0);
    chk(3'd4, 32'h1000_0000, 0, 0, "R6 low bits ignored");
    step(1, 3'd0, 32'hFFFF_FFFF, 0, 0, 0);
    chk(3'd0, 32'h0000_0000, 0, 0, "R7 lower word reads zero");
    chk(3'd4, 32'h1000_0000, 0, 0, "R7 lower write ignored");
    step(1, 3'd4, 32'h2000_0000, 0, 0, 0);
    chk(3'd4, 32'h3000_0000, 1, 0, "R9 soft external request");
    chk(3'd4, 32'h3000_0000, 0, 0, "R11 pulse ends");
    step(0, 3'd4, 0, 1, 0, 0);
    chk(3'd4, 32'h3000_0000, 0, 0, "R9 no re-arm");
    step(1, 3'd4, 32'h0000_0000, 0, 0, 0);
    chk(3'd4, 32'h3000_0000, 0, 0, "R5 zero write keeps set bits");
    step(1, 3'd4, 32'h4000_0000, 0, 0, 0);
    chk(3'd4, 32'h7000_0000, 1, 1, "R8 soft power-on request");
    chk(3'd4, 32'h7000_0000, 0, 0, "R11 pulse ends after por");
    step(0, 3'd4, 0, 1, 0, 0);
    chk(3'd4, 32'h8000_0000, 0, 0, "R8 re-armed reset loads power-on");
    step(0, 3'd4, 0, 1, 0, 0);
    chk(3'd4, 32'h8000_0000, 0, 0, "R3 reset after re-arm consumed");
    step(1, 3'd4, 32'h9000_0000, 0, 1, 0);
    chk(3'd4, 32'h1000_0000, 0, 0, "R10 event beats clear");
    step(1, 3'd4, 32'h6000_0000, 0, 0, 0);
    chk(3'd4, 32'h7000_0000, 1, 1, "R8 both request bits");
    chk(3'd4, 32'h7000_0000, 0, 0, "R11 single pulse");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule